// File: doc/BRIEF.md
# Four-Channel Arbitrary Transmit Pulse Shaper

This block shapes the transmit pulses of four line channels. Each channel keeps eight programmable amplitude samples. While that channel sends a mark, the block plays the samples out one after another, so that the eight segments fill exactly one line-clock period. A host writes and reads the samples through a small register port with a 7-bit address. Each sample holds a sign bit and a 6-bit magnitude.

The block converts each sample to a signed 8-bit two's complement value for a downstream DAC. A per-channel polarity input inverts the whole waveform. If a channel sends a space, or its arbitrary-shape mode is off, that channel's output stays at zero. Line coding is not part of this block. So are the analog driver, clock recovery and jitter attenuation.

Two inputs drive the segment sequencer. The first is an enable that pulses at eight times the line rate. The second is a start strobe that marks the first segment of each line period. The mark and polarity inputs are latched at that start, so they can change freely between starts.

Top module: `arb_pulse_shaper`

## Requirements
- R1: After reset, all 32 sample registers read 0x00, including the reserved bit 7. Every channel output is zero until the first line start.
- R2: An address selects a sample register only when bit 6 is 0 and bit 3 is 1. Bits 5:4 then give the channel and bits 2:0 give the segment, with 000 meaning segment 1. A write to such an address stores all 8 data bits, including reserved bit 7, and a read returns them on the same cycle.
- R3: A write to any other address changes no register. A read from any other address returns 0x00.
- R4: A clock cycle with both seg_tick_i and line_start_i high sets the sequencer to segment 1. A cycle with seg_tick_i high and line_start_i low advances it by one segment, and after segment 8 it wraps to segment 1. Without seg_tick_i the segment holds.
- R5: mark_i and neg_i are sampled only in the cycle that starts a line. A channel that sampled a space (mark 0) outputs zero in every segment of that line.
- R6: For a mark with neg 0, the output is the current segment's sample as an 8-bit two's complement value. Sample bit 6 is the sign (1 means negative) and bits 5:0 are the magnitude. Bit 7 has no effect on the output.
- R7: For a mark with neg 1, the output is the arithmetic negation of the value given by R6.
- R8: A sample with magnitude 0 outputs 0 whatever its sign bit and polarity, so negative zero maps to zero.
- R9: A channel whose arb_mode_i bit is 0 outputs zero, whatever its samples, mark or polarity.
- R10: Each channel uses only its own samples, mode, mark and polarity. The four channels share only the segment index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational from address) |
| seg_tick_i | input | 1 | Segment enable at eight times the line rate |
| line_start_i | input | 1 | Marks the tick that begins a line period |
| arb_mode_i | input | 4 | Per-channel arbitrary-shape enable |
| mark_i | input | 4 | Per-channel mark (1) or space (0), latched at line start |
| neg_i | input | 4 | Per-channel negative polarity, latched at line start |
| amp_o | output | 32 | Four signed 8-bit amplitudes, channel n in bits 8n+7:8n |

## Verification
A wrong segment index moves the waveform in time. With distinct samples on each channel, every output shows the error on the first tick after it occurs, and a counter that fails to wrap shows up on the ninth tick of a line. If a mark or polarity latch is corrupt, or is not held between starts, the output shows the wrong sign or zero within one tick, because the bench changes mark_i and neg_i right after every start. A register file that stores to the wrong place, or that accepts a write it should ignore, shows at the next read of the affected address. It also shows as soon as the sequencer reaches that segment on an enabled channel.

// File: rtl/aps_pkg.sv
package aps_pkg;
  localparam int APS_NUM_CH  = 4;
  localparam int APS_NUM_SEG = 8;
  localparam int APS_DATA_W  = 8;
  localparam int APS_ADDR_W  = 7;
  localparam int APS_OUT_W   = 8;
endpackage

// File: rtl/aps_regfile.sv
module aps_regfile #(
  parameter int NUM_CH  = aps_pkg::APS_NUM_CH,
  parameter int NUM_SEG = aps_pkg::APS_NUM_SEG,
  parameter int DATA_W  = aps_pkg::APS_DATA_W,
  parameter int ADDR_W  = aps_pkg::APS_ADDR_W,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int SEG_W  = $clog2(NUM_SEG),
  localparam int SMP_W  = DATA_W - 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rdata_o,
  output logic [NUM_CH*NUM_SEG*SMP_W-1:0] smp_o
);
  localparam int UP_LSB = SEG_W + 1 + CH_W;

  logic [DATA_W-1:0] mem_q [NUM_CH][NUM_SEG];
  logic [CH_W-1:0]   ch_idx;
  logic [SEG_W-1:0]  seg_idx;
  logic              hit;

  // layout: upper bits zero | channel | select bit | segment
  assign seg_idx = addr_i[SEG_W-1:0];
  assign ch_idx  = addr_i[SEG_W+1 +: CH_W];
  assign hit     = ((addr_i >> UP_LSB) == '0) && addr_i[SEG_W]
                   && ({1'b0, ch_idx} < (CH_W+1)'(NUM_CH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NUM_CH; c++)
        for (int s = 0; s < NUM_SEG; s++)
          mem_q[c][s] <= '0;
    end else if (we_i && hit) begin
      mem_q[ch_idx][seg_idx] <= wdata_i;
    end
  end

  assign rdata_o = hit ? mem_q[ch_idx][seg_idx] : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      assign smp_o[(c*NUM_SEG+s)*SMP_W +: SMP_W] = mem_q[c][s][SMP_W-1:0];
    end
  end
endmodule

// File: rtl/aps_seq.sv
module aps_seq #(
  parameter int NUM_CH  = aps_pkg::APS_NUM_CH,
  parameter int NUM_SEG = aps_pkg::APS_NUM_SEG,
  localparam int SEG_W  = $clog2(NUM_SEG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seg_tick_i,
  input  logic              line_start_i,
  input  logic [NUM_CH-1:0] mark_i,
  input  logic [NUM_CH-1:0] neg_i,
  output logic [SEG_W-1:0]  seg_o,
  output logic [NUM_CH-1:0] mark_o,
  output logic [NUM_CH-1:0] neg_o
);
  logic [SEG_W-1:0]  seg_q;
  logic [NUM_CH-1:0] mark_q, neg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q  <= '0;
      mark_q <= '0;
      neg_q  <= '0;
    end else if (seg_tick_i) begin
      if (line_start_i) begin
        seg_q  <= '0;
        mark_q <= mark_i;
        neg_q  <= neg_i;
      end else if (seg_q == SEG_W'(NUM_SEG-1)) begin
        seg_q <= '0;
      end else begin
        seg_q <= seg_q + 1'b1;
      end
    end
  end

  assign seg_o  = seg_q;
  assign mark_o = mark_q;
  assign neg_o  = neg_q;
endmodule

// File: rtl/aps_chan.sv
module aps_chan #(
  parameter int NUM_SEG = aps_pkg::APS_NUM_SEG,
  parameter int DATA_W  = aps_pkg::APS_DATA_W,
  parameter int OUT_W   = aps_pkg::APS_OUT_W,
  localparam int SEG_W  = $clog2(NUM_SEG),
  localparam int SMP_W  = DATA_W - 1,
  localparam int MAG_W  = DATA_W - 2
) (
  input  logic [NUM_SEG*SMP_W-1:0] smp_i,
  input  logic [SEG_W-1:0]         seg_i,
  input  logic                     en_i,
  input  logic                     mark_i,
  input  logic                     neg_i,
  output logic [OUT_W-1:0]         amp_o
);
  logic [SMP_W-1:0] cur;
  logic [OUT_W-1:0] mag_ext;
  logic             flip;

  assign cur     = smp_i[seg_i*SMP_W +: SMP_W];
  assign mag_ext = {{(OUT_W-MAG_W){1'b0}}, cur[MAG_W-1:0]};
  assign flip    = cur[MAG_W] ^ neg_i;

  always_comb begin
    if (!en_i || !mark_i || mag_ext == '0) amp_o = '0;
    else if (flip)                         amp_o = '0 - mag_ext;
    else                                   amp_o = mag_ext;
  end
endmodule

// File: rtl/arb_pulse_shaper.sv
module arb_pulse_shaper #(
  parameter int NUM_CH  = aps_pkg::APS_NUM_CH,
  parameter int NUM_SEG = aps_pkg::APS_NUM_SEG,
  parameter int DATA_W  = aps_pkg::APS_DATA_W,
  parameter int ADDR_W  = aps_pkg::APS_ADDR_W,
  parameter int OUT_W   = aps_pkg::APS_OUT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_we_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic [DATA_W-1:0]       reg_wdata_i,
  output logic [DATA_W-1:0]       reg_rdata_o,
  input  logic                    seg_tick_i,
  input  logic                    line_start_i,
  input  logic [NUM_CH-1:0]       arb_mode_i,
  input  logic [NUM_CH-1:0]       mark_i,
  input  logic [NUM_CH-1:0]       neg_i,
  output logic [NUM_CH*OUT_W-1:0] amp_o
);
  localparam int SEG_W = $clog2(NUM_SEG);
  localparam int SMP_W = DATA_W - 1;
  localparam int CH_BLK = NUM_SEG * SMP_W;

  logic [NUM_CH*CH_BLK-1:0] smp;
  logic [SEG_W-1:0]         seg_q;
  logic [NUM_CH-1:0]        mark_q, neg_q;

  aps_regfile #(
    .NUM_CH(NUM_CH), .NUM_SEG(NUM_SEG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .smp_o(smp)
  );

  aps_seq #(.NUM_CH(NUM_CH), .NUM_SEG(NUM_SEG)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .seg_tick_i(seg_tick_i),
    .line_start_i(line_start_i), .mark_i(mark_i), .neg_i(neg_i),
    .seg_o(seg_q), .mark_o(mark_q), .neg_o(neg_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    aps_chan #(.NUM_SEG(NUM_SEG), .DATA_W(DATA_W), .OUT_W(OUT_W)) u_chan (
      .smp_i(smp[c*CH_BLK +: CH_BLK]), .seg_i(seg_q), .en_i(arb_mode_i[c]),
      .mark_i(mark_q[c]), .neg_i(neg_q[c]), .amp_o(amp_o[c*OUT_W +: OUT_W])
    );
  end
endmodule

// File: rtl/aps_chk.sv
module aps_chk #(
  parameter int NUM_CH  = 4,
  parameter int NUM_SEG = 8,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 7,
  parameter int OUT_W   = 8,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int SEG_W  = $clog2(NUM_SEG),
  localparam int MAXV   = (1 << (DATA_W-2)) - 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    reg_we_i,
  input logic [ADDR_W-1:0]       reg_addr_i,
  input logic [DATA_W-1:0]       reg_wdata_i,
  input logic [DATA_W-1:0]       reg_rdata_o,
  input logic                    seg_tick_i,
  input logic                    line_start_i,
  input logic [NUM_CH-1:0]       arb_mode_i,
  input logic [NUM_CH-1:0]       mark_i,
  input logic [NUM_CH*OUT_W-1:0] amp_o,
  input logic [SEG_W-1:0]        seg_q
);
  logic hit;
  assign hit = ((reg_addr_i >> (SEG_W+1+CH_W)) == '0) && reg_addr_i[SEG_W]
               && ({1'b0, reg_addr_i[SEG_W+1 +: CH_W]} < (CH_W+1)'(NUM_CH));

  // R2
  wr_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && hit) |=> (reg_addr_i != $past(reg_addr_i)) || (reg_rdata_o == $past(reg_wdata_i)));

  // R3
  miss_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> reg_rdata_o == '0);

  // R4
  seg_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_tick_i && line_start_i) |=> seg_q == '0);

  // R4
  seg_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_tick_i && !line_start_i && seg_q == SEG_W'(NUM_SEG-1)) |=> seg_q == '0);

  // R4
  seg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seg_tick_i |=> $stable(seg_q));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R9
    mode_off_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !arb_mode_i[c] |-> amp_o[c*OUT_W +: OUT_W] == '0);
    // R5
    space_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seg_tick_i && line_start_i && !mark_i[c]) |=> amp_o[c*OUT_W +: OUT_W] == '0);
    // R6
    amp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($signed(amp_o[c*OUT_W +: OUT_W]) <= MAXV) && ($signed(amp_o[c*OUT_W +: OUT_W]) >= -MAXV));
  end
endmodule

bind arb_pulse_shaper aps_chk #(
  .NUM_CH(NUM_CH), .NUM_SEG(NUM_SEG), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OUT_W(OUT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .seg_tick_i(seg_tick_i),
  .line_start_i(line_start_i), .arb_mode_i(arb_mode_i), .mark_i(mark_i),
  .amp_o(amp_o), .seg_q(seg_q)
);

// File: tb/arb_pulse_shaper_tb.sv
module arb_pulse_shaper_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        we = 0;
  logic [6:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        tick = 0, start = 0;
  logic [3:0]  mode = '0, mark = '0, neg = '0;
  logic [31:0] amp;

  int checks = 0, errors = 0;
  logic [7:0] model [4][8];
  int exp_seg = 0;
  logic [3:0] lat_mark = '0, lat_neg = '0;

  always #10 clk = ~clk;

  arb_pulse_shaper u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .seg_tick_i(tick),
    .line_start_i(start), .arb_mode_i(mode), .mark_i(mark), .neg_i(neg),
    .amp_o(amp)
  );

  function automatic bit addr_hit(logic [6:0] a);
    return (a[6] == 1'b0) && a[3];
  endfunction

  function automatic logic [7:0] exp_amp(logic [7:0] s, bit en, bit mk, bit ng);
    logic [7:0] m;
    m = {2'b00, s[5:0]};
    if (!en || !mk || m == 0) return 8'h00;
    return (s[6] ^ ng) ? 8'h00 - m : m;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag_ovr);
    for (int c = 0; c < 4; c++) begin
      logic [7:0] s, e;
      string tag;
      s = model[c][exp_seg];
      e = exp_amp(s, mode[c], lat_mark[c], lat_neg[c]);
      if (tag_ovr != "") tag = tag_ovr;
      else if (!mode[c]) tag = "R9";
      else if (!lat_mark[c]) tag = "R5";
      else if (s[5:0] == 0) tag = "R8";
      else if (lat_neg[c]) tag = "R7";
      else tag = "R6";
      check(tag, 32'(amp[c*8 +: 8]), 32'(e), $sformatf("ch%0d seg%0d amp", c, exp_seg));
    end
  endtask

  task automatic reg_write(logic [6:0] a, logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
    if (addr_hit(a)) model[a[5:4]][a[2:0]] = d;
  endtask

  task automatic reg_read_chk(logic [6:0] a, string tag);
    @(negedge clk); addr = a; #1;
    check(tag, 32'(rdata), addr_hit(a) ? 32'(model[a[5:4]][a[2:0]]) : 32'h0,
          $sformatf("read addr %h", a));
  endtask

  task automatic do_tick(bit st, logic [3:0] mk, logic [3:0] ng);
    @(negedge clk); tick = 1; start = st; mark = mk; neg = ng;
    @(negedge clk); tick = 0; start = 0;
    mark = 4'($urandom); neg = 4'($urandom);  // must not matter until next start
    if (st) begin exp_seg = 0; lat_mark = mk; lat_neg = ng; end
    else exp_seg = (exp_seg + 1) % 8;
  endtask

  task automatic run_line(logic [3:0] mk, logic [3:0] ng, string tag_ovr, bit idles);
    for (int s = 0; s < 8; s++) begin
      do_tick(s == 0, mk, ng);
      check_all(tag_ovr);
      if (idles) begin
        int n = $urandom_range(0, 2);
        for (int k = 0; k < n; k++) begin
          @(negedge clk);
          check_all("R4");
        end
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int c = 0; c < 4; c++) for (int s = 0; s < 8; s++) model[c][s] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    mode = 4'hF;
    @(negedge clk);
    // R1 reset state
    check_all("R1");
    for (int a = 0; a < 128; a++) if (addr_hit(7'(a))) reg_read_chk(7'(a), "R1");

    // R3 invalid writes ignored, reads zero
    reg_write(7'h00, 8'hFF); reg_write(7'h07, 8'hFF);
    reg_write(7'h48, 8'hFF); reg_write(7'h7F, 8'hFF); reg_write(7'h31, 8'hAA);
    for (int a = 0; a < 128; a++) reg_read_chk(7'(a), "R3");
    run_line(4'hF, 4'h0, "R3", 0);

    // R2 program every register with random data, read back including bit 7
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 8; s++)
        reg_write({1'b0, 2'(c), 1'b1, 3'(s)}, 8'($urandom));
    reg_write(7'h0B, 8'hC0);   // ch0 seg4: bit7 set, negative zero
    reg_write(7'h0C, 8'h3F);   // ch0 seg5: +63
    reg_write(7'h0D, 8'h7F);   // ch0 seg6: -63
    reg_write(7'h1A, 8'h00);   // ch1 seg3: zero
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 8; s++)
        reg_read_chk({1'b0, 2'(c), 1'b1, 3'(s)}, "R2");

    // R8 negative zero under both polarities
    run_line(4'hF, 4'h0, "", 0);
    run_line(4'hF, 4'hF, "", 0);

    // R10 mixed per-channel settings in one line
    mode = 4'b1011;
    run_line(4'b1101, 4'b0110, "R10", 0);
    mode = 4'hF;

    // R4 wrap without a new start, then restart mid-line
    run_line(4'hF, 4'h5, "", 0);
    for (int k = 0; k < 3; k++) begin do_tick(0, 4'h0, 4'h0); check_all("R4"); end
    do_tick(1, 4'hA, 4'h3); check_all("R4");
    do_tick(0, 4'h0, 4'h0); check_all("R4");

    // random lines with reprogramming, idle gaps and mode changes
    for (int l = 0; l < 300; l++) begin
      if (l % 7 == 3) begin
        int c = $urandom_range(0, 3);
        int s = $urandom_range(0, 7);
        reg_write({1'b0, 2'(c), 1'b1, 3'(s)}, 8'($urandom));
        reg_read_chk({1'b0, 2'(c), 1'b1, 3'(s)}, "R2");
      end
      if (l % 11 == 5) reg_write(7'($urandom) & 7'h77, 8'($urandom)); // miss
      if (l % 5 == 0) mode = 4'($urandom);
      run_line(4'($urandom), 4'($urandom), "", 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule